// File: doc/BRIEF.md
# Periodic Interrupt and Status Flags

This block turns a 32.768 kHz clock-enable pulse into a programmable periodic event and collects three event sources (periodic, alarm, update-ended) into one status byte. Each source has its own flag and its own enable. A summary bit in the same byte, which is also driven out as an interrupt request, is high whenever a set flag meets its enable. Software reads the status byte, and the read clears the flags.

A free-running divider counts the time-base pulses. A 4-bit rate code picks a power-of-two tap of that divider, which sets the periodic interval. The same tick can drive a square-wave output at half the tick rate. The calendar logic that produces the alarm and update-ended pulses sits outside this block. Its pulses arrive here one system clock wide.

Top module: `tick_irq_status`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `stat_q` is 8'h00, `irq` is 0 and `sqw_out` is 0.
- R2: The divider runs only while `base_sel` is 3'b010. Any other code holds it cleared and produces no periodic events. A later switch back to 3'b010 restarts the count from zero.
- R3: Rate code 4'b0000 produces no periodic events, whatever the `base_tick` activity.
- R4: For rate codes 4'b0011 to 4'b1111 a periodic event occurs once every 2^(code-1) `base_tick` pulses. The first event comes on the 2^(code-1)-th pulse after the divider starts from zero.
- R5: Rate code 4'b0001 gives a period of 128 pulses and rate code 4'b0010 gives 256 pulses.
- R6: Status bit 6 is the periodic flag, bit 5 the alarm flag (`alm_evt`) and bit 4 the update-ended flag (`upd_evt`). Each flag is set on the clock edge that follows its event, whether or not its enable is set.
- R7: Status bit 7 is 1 exactly when at least one flag is set together with its enable: `per_en` for bit 6, `alm_en` for bit 5, `upd_en` for bit 4. `irq` always equals bit 7.
- R8: While `stat_rd` is high, `stat_q` shows the current contents, and the next edge clears bits 7:4. An event that arrives in the same cycle as the read leaves its flag set.
- R9: Status bits 3:0 always read 0.
- R10: While `sqw_en` is high, `sqw_out` toggles on each periodic event. While `sqw_en` is low, it is driven low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle pulse at 32.768 kHz |
| base_sel | input | 3 | Time-base select; 3'b010 runs the divider |
| rate_sel | input | 4 | Periodic rate code |
| per_en | input | 1 | Periodic interrupt enable |
| alm_en | input | 1 | Alarm interrupt enable |
| upd_en | input | 1 | Update-ended interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| alm_evt | input | 1 | Alarm event pulse |
| upd_evt | input | 1 | Update-ended event pulse |
| stat_rd | input | 1 | Status read strobe (read-to-clear) |
| stat_q | output | 8 | Status byte: request, flags, zeros |
| irq | output | 1 | Interrupt request, active high |
| sqw_out | output | 1 | Square-wave output |

## Verification
The assertions check four behaviours on every cycle. Alarm and update pulses always leave their flag set on the next cycle, even against a read. A read with no event clears the flag. Rate zero and an idle square-wave enable never produce a tick or a high output. A request is never raised with every enable off. Only the bench's scenarios can show the exact tick spacing of each rate code, including the two short codes that alias to longer periods. They also show the divider restart when the time-base select changes, and the square-wave phase over many ticks.

// File: rtl/tick_irq_status.sv
module tick_irq_status #(
  parameter int DIV_W  = 14,
  parameter int RATE_W = 4,
  parameter logic [2:0] BASE_RUN = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic [2:0]        base_sel,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              per_en,
  input  logic              alm_en,
  input  logic              upd_en,
  input  logic              sqw_en,
  input  logic              alm_evt,
  input  logic              upd_evt,
  input  logic              stat_rd,
  output logic [7:0]        stat_q,
  output logic              irq,
  output logic              sqw_out
);
  localparam int TAP_W = $clog2(DIV_W + 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] tap_mask;
  logic [TAP_W-1:0] tap_len;
  logic [2:0]       flg_q;
  logic             run, rate_on, per_hit;

  assign run     = (base_sel == BASE_RUN);
  assign rate_on = (rate_sel != '0);

  always_comb begin
    case (rate_sel)
      RATE_W'(1): tap_len = TAP_W'(7);
      RATE_W'(2): tap_len = TAP_W'(8);
      default:    tap_len = TAP_W'(rate_sel) - TAP_W'(1);
    endcase
  end

  assign tap_mask = (DIV_W'(1) << tap_len) - DIV_W'(1);
  assign per_hit  = run && rate_on && base_tick && ((div_q & tap_mask) == tap_mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) div_q <= '0;
    else if (base_tick) div_q <= div_q + DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= (stat_rd ? 3'b000 : flg_q) | {per_hit, alm_evt, upd_evt};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !sqw_en) sqw_out <= 1'b0;
    else if (per_hit)      sqw_out <= ~sqw_out;
  end

  assign stat_q = {|(flg_q & {per_en, alm_en, upd_en}), flg_q, 4'h0};
  assign irq    = stat_q[7];
endmodule

module tick_irq_status_chk #(
  parameter int RATE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [RATE_W-1:0] rate_sel,
  input logic              per_en,
  input logic              alm_en,
  input logic              upd_en,
  input logic              sqw_en,
  input logic              alm_evt,
  input logic              upd_evt,
  input logic              stat_rd,
  input logic [7:0]        stat_q,
  input logic              irq,
  input logic              sqw_out
);
  // R6
  alm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n) alm_evt |=> stat_q[5]);
  // R8
  upd_kept_chk: assert property (@(posedge clk) disable iff (!rst_n) upd_evt |=> stat_q[4]);
  // R8
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n) (stat_rd && !alm_evt) |=> !stat_q[5]);
  // R3
  rate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == '0 && !stat_rd) |=> $stable(stat_q[6]));
  // R10
  sqw_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !sqw_en |=> !sqw_out);
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (per_en || alm_en || upd_en));
  // R9
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) stat_q[3:0] == 4'h0);
endmodule

bind tick_irq_status tick_irq_status_chk #(.RATE_W(RATE_W)) u_chk (.*);

// File: tb/sim_tick_irq_status.sv
`timescale 1ns/1ps
module sim_tick_irq_status;
  logic clk = 0, rst_n = 0;
  logic tick = 0, pe = 0, ae = 0, ue = 0, se = 0, alm = 0, upd = 0, rd = 0;
  logic [2:0] bsel = 3'b010;
  logic [3:0] rate = 4'd0;
  logic [7:0] stat_q;
  logic irq, sqw_out;
  int n_chk = 0, n_bad = 0;
  int m_cnt = 0;
  logic [2:0] m_flg = 0;
  logic m_sqw = 0;

  always #10 clk = ~clk;

  tick_irq_status u0 (.clk(clk), .rst_n(rst_n), .base_tick(tick), .base_sel(bsel),
    .rate_sel(rate), .per_en(pe), .alm_en(ae), .upd_en(ue), .sqw_en(se),
    .alm_evt(alm), .upd_evt(upd), .stat_rd(rd), .stat_q(stat_q), .irq(irq), .sqw_out(sqw_out));

  function automatic int plen(input logic [3:0] r);
    if (r == 4'd1) return 128;
    if (r == 4'd2) return 256;
    return 1 << (r - 1);
  endfunction

  task automatic check(input string tag);
    logic [7:0] e;
    e = {|(m_flg & {pe, ae, ue}), m_flg, 4'h0};
    n_chk++;
    if (stat_q !== e || irq !== e[7] || sqw_out !== m_sqw) begin
      n_bad++;
      $display("FAIL %s: stat=%h irq=%b sqw=%b expected stat=%h irq=%b sqw=%b",
               tag, stat_q, irq, sqw_out, e, e[7], m_sqw);
    end
  endtask

  task automatic cyc(input string tag);
    logic per;
    per = (bsel == 3'b010) && tick && (rate != 0) && (((m_cnt + 1) % plen(rate)) == 0);
    @(posedge clk);
    if (bsel != 3'b010) m_cnt = 0;
    else if (tick) m_cnt = (m_cnt + 1) % 16384;
    m_flg = (rd ? 3'b000 : m_flg) | {per, alm, upd};
    m_sqw = !se ? 1'b0 : (per ? ~m_sqw : m_sqw);
    @(negedge clk);
    check(tag);
  endtask

  task automatic run_ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick = 1; rd = (i % 37 == 36);
      cyc(tag);
    end
    tick = 0; rd = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    cyc("R1 after reset");
    cyc("R9 idle");

    // R4: shortest period, every 4 pulses
    rate = 4'd3;
    run_ticks(24, "R4 rate3");
    // R2: other base codes hold the divider
    bsel = 3'b011; pe = 1;
    run_ticks(40, "R2 base held");
    bsel = 3'b010;
    run_ticks(9, "R2 restart");
    rate = 4'd6; run_ticks(70, "R4 rate6");
    // R5: aliased short codes
    rate = 4'd1; run_ticks(300, "R5 rate1");
    rate = 4'd2; run_ticks(540, "R5 rate2");
    // R3: rate zero ignores the time base
    rd = 1; cyc("R8 clear"); rd = 0;
    rate = 4'd0; run_ticks(400, "R3 rate0");
    // R6 / R7: flags without enables, request gated
    pe = 0; alm = 1; cyc("R6 alarm no enable"); alm = 0;
    upd = 1; cyc("R6 update no enable"); upd = 0;
    ae = 1; cyc("R7 enable raises request");
    ae = 0; ue = 1; cyc("R7 update enable");
    // R8: read with simultaneous event
    rd = 1; alm = 1; cyc("R8 event during read"); rd = 0; alm = 0;
    ae = 1; cyc("R8 kept alarm");
    rd = 1; cyc("R8 read clears"); rd = 0;
    cyc("R8 after clear");
    // R10: square wave
    rate = 4'd3; se = 1;
    run_ticks(40, "R10 sqw on");
    se = 0; run_ticks(8, "R10 sqw off");
    // R4: longest period
    rate = 4'd15; pe = 1; se = 1;
    bsel = 3'b000; cyc("R2 hold"); bsel = 3'b010;
    run_ticks(16390, "R4 rate15");
    // mixed random
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom % 2) == 0;
      alm  = ($urandom % 23) == 0;
      upd  = ($urandom % 29) == 0;
      rd   = ($urandom % 11) == 0;
      if (($urandom % 97) == 0) {pe, ae, ue, se} = 4'($urandom);
      if (($urandom % 211) == 0) rate = 4'($urandom);
      if (($urandom % 503) == 0) bsel = (($urandom % 4) == 0) ? 3'b001 : 3'b010;
      cyc("R6 R7 R8 R10 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule